// File: doc/BRIEF.md
# Tear-Free 64-bit Cycle Counter

This block keeps a 64-bit count of clock cycles that software reads as two 32-bit words through a small register port. The count starts and stops under software control. Nothing is latched when a half is read. A small tracker watches the order of reads instead. Reading the low word opens a tracking window, and reading the high word closes it. If the high word moved, or an interrupt or exception was taken while the window was open, a status bit in the control word reads as 0. Software therefore reads low, then high, then control, and repeats the three reads until the status bit reads as 1.

The count belongs to one core. The register port is a plain single-cycle strobe interface. Read data is registered and appears on the clock after the strobe. A parameter sets the value loaded into the count by reset. Its default is zero.

Top module: `tear_free_counter`

## Requirements
- R1: A synchronous active-high reset loads the count with RESET_COUNT (zero by default) and stops counting. After reset a read of the control word returns all zeros, so the status flag is 0.
- R2: Writing the control word with bit 0 = 1 starts counting, and the count then rises by one on every clock. Writing bit 0 = 0 stops it, and the count then holds its value.
- R3: The control word is at BASE_ADDR (0x103), the low half at BASE_ADDR+1 and the high half at BASE_ADDR+2. Read data appears on rd_data on the clock after rd_en. Any other address reads as zero. Writes to the low and high addresses change nothing.
- R4: In a control read, bit 0 shows the enable state, bit 31 shows the status flag, and bits 30 down to 1 are zero.
- R5: The high half increments on exactly the clock edge at which the low half wraps from all ones to zero.
- R6: A read of the low half opens a tracking window and sets the status flag to 1. If a carry or exc_taken occurs in that same cycle, the flag is set to 0 instead.
- R7: A carry into the high half on the edge at the end of any cycle from the low read up to, but not including, the high read clears the status flag.
- R8: exc_taken high in any cycle from the low read up to, but not including, the high read clears the status flag.
- R9: A read of the high half closes the window. A carry or exc_taken in the high-read cycle or later leaves the flag unchanged until the next low read. A high read with no open window also leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe for addr |
| wr_en | input | 1 | Write strobe for addr |
| addr | input | 12 | Register address |
| wdata | input | 32 | Write data |
| exc_taken | input | 1 | High for a cycle in which an interrupt or exception was taken |
| rd_data | output | 32 | Registered read data, valid on the clock after rd_en |

## Verification
The hard cases are cycles in which a read of one half falls on the same cycle as a carry from the low half, or as an asserted exc_taken. The bench brings the count next to its wrap point with the reset preset. It polls the low half until it knows the count exactly, then waits a computed number of idle cycles. This places the low read, the high read, or an idle cycle inside the window on the carry edge. A stimulus table then moves a one-cycle exc_taken pulse across the cycles before, within and after the window. In every case the expected status is taken from the window rule, and both halves are compared against the known count.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  // Which register the current address selects.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LOW  = 2'd2,
    SEL_HIGH = 2'd3
  } reg_sel_e;

  // Bit of the control word that shows the enable state.
  localparam int RUN_BIT = 0;

endpackage

// File: rtl/tfc_counter.sv
module tfc_counter #(
  parameter int                     HALF_W      = 32,
  parameter logic [2*HALF_W-1:0]    RESET_COUNT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic [HALF_W-1:0] count_lo,
  output logic [HALF_W-1:0] count_hi,
  output logic              carry_hi
);

  localparam int NUM_LANES = 2;

  logic [NUM_LANES-1:0][HALF_W-1:0] lane_q;
  logic [NUM_LANES-1:0]             inc_chain;

  // Each lane steps when counting is on and every lane below it is all ones.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign inc_chain[g] = run;
    end else begin : g_upper
      assign inc_chain[g] = inc_chain[g-1] & (&lane_q[g-1]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[g] <= RESET_COUNT[g*HALF_W +: HALF_W];
      end else if (inc_chain[g]) begin
        lane_q[g] <= lane_q[g] + HALF_W'(1);
      end
    end
  end

  assign count_lo = lane_q[0];
  assign count_hi = lane_q[1];
  assign carry_hi = inc_chain[1];

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable({count_hi, count_lo})); // R2

  AST_CARRY_STEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
    carry_hi |=> (count_hi == $past(count_hi) + HALF_W'(1)) && (count_lo == '0)); // R5

  AST_NO_CARRY_HIGH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !carry_hi |=> $stable(count_hi)); // R5

endmodule

// File: rtl/tfc_tracker.sv
module tfc_tracker (
  input  logic clk,
  input  logic rst,
  input  logic rd_low,
  input  logic rd_high,
  input  logic carry_hi,
  input  logic exc_taken,
  output logic atomic
);

  logic win_open_q;
  logic atomic_q;
  logic disturb;

  assign disturb = carry_hi | exc_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open_q <= 1'b0;
      atomic_q   <= 1'b0;
    end else if (rd_low) begin
      win_open_q <= 1'b1;
      atomic_q   <= ~disturb;
    end else if (rd_high) begin
      win_open_q <= 1'b0;
    end else if (win_open_q && disturb) begin
      atomic_q   <= 1'b0;
    end
  end

  assign atomic = atomic_q;

  AST_LOW_OPENS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    rd_low |=> win_open_q); // R6

  AST_CLEAN_START: assert property (@(posedge clk) disable iff (rst)
    rd_low && !carry_hi && !exc_taken |=> atomic_q); // R6

  AST_CARRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((win_open_q && !rd_high) || rd_low) && carry_hi |=> !atomic_q); // R7

  AST_EXC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((win_open_q && !rd_high) || rd_low) && exc_taken |=> !atomic_q); // R8

  AST_HIGH_CLOSES: assert property (@(posedge clk) disable iff (rst)
    rd_high && !rd_low |=> !win_open_q && $stable(atomic_q)); // R9

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !win_open_q && !rd_low |=> $stable(atomic_q)); // R9

endmodule

// File: rtl/tfc_regs.sv
module tfc_regs
  import tfc_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h103
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count_lo,
  input  logic [DATA_W-1:0] count_hi,
  input  logic              atomic,
  output logic              run,
  output logic              rd_low,
  output logic              rd_high,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] LOW_ADDR  = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] HIGH_ADDR = BASE_ADDR + ADDR_W'(2);
  localparam int                STAT_BIT  = DATA_W - 1;

  reg_sel_e          sel;
  logic              run_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:1];

  always_comb begin
    if (addr == CTRL_ADDR)      sel = SEL_CTRL;
    else if (addr == LOW_ADDR)  sel = SEL_LOW;
    else if (addr == HIGH_ADDR) sel = SEL_HIGH;
    else                        sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (wr_en && sel == SEL_CTRL) begin
      run_q <= wdata[RUN_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: begin
        rd_mux[STAT_BIT] = atomic;
        rd_mux[RUN_BIT]  = run_q;
      end
      SEL_LOW:  rd_mux = count_lo;
      SEL_HIGH: rd_mux = count_hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_mux;
    end
  end

  assign run     = run_q;
  assign rd_low  = rd_en && (sel == SEL_LOW);
  assign rd_high = rd_en && (sel == SEL_HIGH);
  assign rd_data = rd_q;

  AST_CTRL_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && (addr == CTRL_ADDR) |=> rd_data[STAT_BIT-1:1] == '0); // R4

  AST_CTRL_SHOWS_RUN: assert property (@(posedge clk) disable iff (rst)
    rd_en && (addr == CTRL_ADDR) |=> rd_data[RUN_BIT] == $past(run_q)); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && (addr != CTRL_ADDR) && (addr != LOW_ADDR) && (addr != HIGH_ADDR)
    |=> rd_data == '0); // R3

  AST_READ_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_low && rd_high)); // R3

endmodule

// File: rtl/tear_free_counter.sv
module tear_free_counter #(
  parameter int                  ADDR_W      = 12,
  parameter int                  DATA_W      = 32,
  parameter logic [ADDR_W-1:0]   BASE_ADDR   = 12'h103,
  parameter logic [2*DATA_W-1:0] RESET_COUNT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              exc_taken,
  output logic [DATA_W-1:0] rd_data
);

  logic              run;
  logic              rd_low;
  logic              rd_high;
  logic              carry_hi;
  logic              atomic;
  logic [DATA_W-1:0] count_lo;
  logic [DATA_W-1:0] count_hi;

  tfc_counter #(
    .HALF_W      (DATA_W),
    .RESET_COUNT (RESET_COUNT)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .count_lo (count_lo),
    .count_hi (count_hi),
    .carry_hi (carry_hi)
  );

  tfc_tracker u_tracker (
    .clk       (clk),
    .rst       (rst),
    .rd_low    (rd_low),
    .rd_high   (rd_high),
    .carry_hi  (carry_hi),
    .exc_taken (exc_taken),
    .atomic    (atomic)
  );

  tfc_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .count_lo (count_lo),
    .count_hi (count_hi),
    .atomic   (atomic),
    .run      (run),
    .rd_low   (rd_low),
    .rd_high  (rd_high),
    .rd_data  (rd_data)
  );

  AST_RESET_STOPS: assert property (@(posedge clk)
    rst |=> !run && !atomic); // R1

endmodule

// File: tb/test_tear_free_counter.sv
`timescale 1ns/1ps
module test_tear_free_counter;

  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LOW  = 12'h104;
  localparam logic [11:0] A_HIGH = 12'h105;
  localparam logic [63:0] PRESET = 64'h0000_0002_FFFF_FFF0;

  typedef struct packed {
    logic [3:0] gap;      // idle cycles between low and high read
    logic [3:0] exc_pos;  // 0 none, k: cycle k-1 after low read, 15: cycle before
    logic       ok;       // expected status flag
  } row_t;

  localparam int NROWS = 10;
  localparam row_t TABLE [NROWS] = '{
    '{4'd0, 4'd0,  1'b1},
    '{4'd0, 4'd1,  1'b0},
    '{4'd0, 4'd2,  1'b1},
    '{4'd0, 4'd3,  1'b1},
    '{4'd2, 4'd0,  1'b1},
    '{4'd2, 4'd2,  1'b0},
    '{4'd2, 4'd3,  1'b0},
    '{4'd2, 4'd4,  1'b1},
    '{4'd3, 4'd6,  1'b1},
    '{4'd1, 4'd15, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        exc_taken = 1'b0;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  tear_free_counter #(
    .RESET_COUNT (PRESET)
  ) i_tear_free_counter (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .exc_taken (exc_taken),
    .rd_data   (rd_data)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rd, input logic [11:0] a, input logic x, output logic [31:0] d);
    rd_en = rd; addr = a; exc_taken = x;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0; exc_taken = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Poll the low half until it is at or above a threshold; return that value.
  task automatic poll_low(output logic [31:0] v);
    v = '0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, A_LOW, 1'b0, v);
      if (v >= 32'hFFFF_FFF8) break;
    end
  endtask

  // Idle until the next low read sees value target, then perform that read.
  task automatic read_low_at(input logic [31:0] v, input logic [31:0] target, output logic [31:0] d);
    for (int i = 0; i < int'(target - v) - 1; i++) cyc(1'b0, A_LOW, 1'b0, d);
    cyc(1'b1, A_LOW, 1'b0, d);
  endtask

  initial begin
    logic [31:0] d, v, a, b;
    @(negedge clk);
    do_reset();

    // R1: reset state
    cyc(1'b1, A_CTRL, 1'b0, d); check(d, 32'h0, "R1 ctrl after reset");
    cyc(1'b1, A_LOW,  1'b0, d); check(d, PRESET[31:0], "R1 low after reset");
    cyc(1'b1, A_HIGH, 1'b0, d); check(d, PRESET[63:32], "R1 high after reset");

    // R3: unmapped reads and ignored writes
    cyc(1'b1, 12'h106, 1'b0, d); check(d, 32'h0, "R3 unmapped above");
    cyc(1'b1, 12'h102, 1'b0, d); check(d, 32'h0, "R3 unmapped below");
    wr(A_LOW, 32'h1234_5678);
    wr(A_HIGH, 32'h0000_00AB);
    cyc(1'b1, A_LOW,  1'b0, d); check(d, PRESET[31:0], "R3 low write ignored");
    cyc(1'b1, A_HIGH, 1'b0, d); check(d, PRESET[63:32], "R3 high write ignored");

    // R2: enable, count by one per clock
    wr(A_CTRL, 32'h1);
    cyc(1'b1, A_LOW, 1'b0, a);
    cyc(1'b1, A_LOW, 1'b0, b);
    check(b, a + 32'd1, "R2 count step");
    cyc(1'b1, A_CTRL, 1'b0, d); check(d & 32'h7FFF_FFFF, 32'h1, "R4 run bit and pad");

    // R6/R7: low read on the carry cycle -> torn, high already moved (R5)
    poll_low(v);
    read_low_at(v, 32'hFFFF_FFFF, d); check(d, 32'hFFFF_FFFF, "R5 low at wrap point");
    cyc(1'b1, A_HIGH, 1'b0, d); check(d, 32'h3, "R5 high after carry");
    cyc(1'b1, A_CTRL, 1'b0, d); check(d, 32'h0000_0001, "R6 carry in low-read cycle");

    // R9: carry in the high-read cycle does not tear
    do_reset();
    wr(A_CTRL, 32'h1);
    poll_low(v);
    read_low_at(v, 32'hFFFF_FFFE, d); check(d, 32'hFFFF_FFFE, "R9 low before wrap");
    cyc(1'b1, A_HIGH, 1'b0, d); check(d, 32'h2, "R9 high before carry");
    cyc(1'b1, A_CTRL, 1'b0, d); check(d, 32'h8000_0001, "R9 carry in high-read cycle");
    cyc(1'b1, A_HIGH, 1'b0, d); check(d, 32'h3, "R5 high incremented");
    cyc(1'b1, A_CTRL, 1'b0, d); check(d, 32'h8000_0001, "R9 lone high read keeps flag");

    // R7: carry in an idle cycle inside the window
    do_reset();
    wr(A_CTRL, 32'h1);
    poll_low(v);
    read_low_at(v, 32'hFFFF_FFFD, d); check(d, 32'hFFFF_FFFD, "R7 low before wrap");
    cyc(1'b0, A_LOW, 1'b0, d);
    cyc(1'b0, A_LOW, 1'b0, d);
    cyc(1'b1, A_HIGH, 1'b0, d); check(d, 32'h3, "R7 high after carry");
    cyc(1'b1, A_CTRL, 1'b0, d); check(d, 32'h0000_0001, "R7 carry in window");

    // R2: disable holds the count
    wr(A_CTRL, 32'h0);
    cyc(1'b1, A_LOW, 1'b0, a);
    cyc(1'b0, A_LOW, 1'b0, d);
    cyc(1'b1, A_LOW, 1'b0, b);
    check(b, a, "R2 hold when disabled");
    cyc(1'b1, A_CTRL, 1'b0, d); check(d & 32'h7FFF_FFFF, 32'h0, "R2 run bit cleared");
    cyc(1'b1, A_HIGH, 1'b0, d); check(d, 32'h3, "R2 high holds");
    wr(A_CTRL, 32'h1);

    // R8/R9 table: exc pulse placed around the window
    for (int r = 0; r < NROWS; r++) begin
      row_t row;
      int   g;
      row = TABLE[r];
      g = int'(row.gap);
      cyc(1'b0, A_LOW, row.exc_pos == 4'd15, d);
      for (int c = 0; c <= g + 2; c++) begin
        logic x;
        x = (row.exc_pos != 4'd0) && (row.exc_pos != 4'd15) && (int'(row.exc_pos) == c + 1);
        if (c == 0)          cyc(1'b1, A_LOW,  x, a);
        else if (c == g + 1) cyc(1'b1, A_HIGH, x, b);
        else                 cyc(1'b0, A_LOW,  x, d);
      end
      check(b, 32'h3, "R8 table high half");
      cyc(1'b1, A_CTRL, 1'b0, d);
      check(d, {row.ok, 30'b0, 1'b1}, "R8 table status");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule